// File: doc/BRIEF.md
# Interrupt Router with Legacy Takeover

This block sits behind a bank of timer channels and turns each channel's fire event into an interrupt. Depending on its configuration, a channel either drives one of 32 interrupt lines or requests a 32-bit memory write that carries a message. A line can be driven in two ways. A level-type channel latches a status bit and keeps its line high until software clears that bit. An edge-type channel gives a single-cycle pulse.

A global legacy bit switches the block into a takeover mode. In that mode channel 0 is tied to line 0 and channel 1 to line 8. An external interval-timer interrupt and a real-time-clock interrupt normally pass through to those same two lines. In takeover mode both are blocked, and an enable output tells the external interval timer to stop. The clock input's level is always recorded, so line 8 can be restored to that level when takeover mode ends.

Message writes leave the block through a valid/ready port. Each channel can hold one pending request, and the lowest-numbered pending channel is served first.

Top module: `irq_legacy_router`

## Requirements
- R1: Outside legacy mode, channel c drives line `ch_route_i[c]`, a 5-bit line index. In legacy mode, channel 0 drives line 0 and channel 1 drives line 8 whatever their route fields hold; the other channels still use their route fields. Contributions from all sources to the same line are ORed.
- R2: An accepted fire (channel enable, global enable, message enable 0, `ch_lvl_i`=1 for level type) sets `status_o[c]` at the next edge. The routed line is high from then until a `stat_clr_i[c]` strobe clears the bit. If a fire and a clear strobe reach the same channel in one cycle, the fire wins.
- R3: An accepted fire on an edge-type channel (`ch_lvl_i`=0) drives its line high for exactly the one cycle after the fire. The status bit is not touched.
- R4: An accepted fire with message enable 1 drives no line. It raises `msg_valid_o` at the next edge, with `msg_addr_o`/`msg_data_o` set to the channel's address and data words as they were at the fire. These values stay stable until `msg_ready_i` is seen. The lowest pending channel index is served first. Further fires on a channel that already has a request pending are dropped.
- R5: A fire on a channel whose own enable or the global enable is 0 clears that channel's status bit and lowers its level line. It produces no pulse and no message.
- R6: A 0-to-1 change of a channel's message enable clears its status bit at the next edge.
- R7: Outside legacy mode, line 0 follows `pit_irq_i` and line 8 follows `rtc_irq_i`, each one edge later.
- R8: One edge after `legacy_i` goes to 1, `pit_en_o` is 0 and the external inputs no longer reach lines 0 and 8. This holds for as long as legacy mode stays on.
- R9: On the first edge after `legacy_i` returns to 0: the external part of line 0 is 0, `pit_en_o` is 1, and line 8 takes the last recorded `rtc_irq_i` level, which is recorded even during legacy mode.
- R10: After reset, `irq_o` is 0, `status_o` is 0, `msg_valid_o` is 0, `pit_en_o` is 1 and the recorded clock level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| fire_i | input | NUM_CH | Per-channel fire event, one cycle |
| ch_en_i | input | NUM_CH | Per-channel interrupt enable |
| ch_lvl_i | input | NUM_CH | 1 = level type, 0 = edge type |
| ch_msg_en_i | input | NUM_CH | Message delivery instead of a line |
| ch_route_i | input | NUM_CH x 5 | Line index per channel |
| ch_msg_addr_i | input | NUM_CH x 32 | Message address per channel |
| ch_msg_data_i | input | NUM_CH x 32 | Message data per channel |
| glb_en_i | input | 1 | Global enable |
| legacy_i | input | 1 | Legacy takeover mode |
| stat_clr_i | input | NUM_CH | Status clear strobes |
| pit_irq_i | input | 1 | External interval-timer interrupt |
| rtc_irq_i | input | 1 | External clock interrupt level |
| irq_o | output | 32 | Interrupt lines |
| status_o | output | NUM_CH | Level status bits |
| msg_valid_o | output | 1 | Message write request valid |
| msg_ready_i | input | 1 | Message write accepted |
| msg_addr_o | output | 32 | Message write address |
| msg_data_o | output | 32 | Message write data |
| pit_en_o | output | 1 | Enable for the external interval timer |

## Verification
The assertions assume that fire, clear and configuration inputs change only between clock edges. They also assume that a channel's message enable does not change in the same cycle as a fire on that channel, and that `msg_ready_i` is the only thing that ends a pending request. The stimulus changes every input at the falling edge and holds each configuration steady across a fire. It sweeps every route value on every channel, then runs the level, blocking, message and legacy sequences one at a time, so no two of these events overlap in a way the assertions do not expect.

// File: rtl/irq_router_pkg.sv
// Shared constants and types for the interrupt router.
// Assumes a 32-line interrupt fabric addressed by a 5-bit line index.
package irq_router_pkg;
    localparam int ROUTE_W   = 5;
    localparam int NUM_LINES = 2 ** ROUTE_W;
    localparam int MSG_W     = 32;

    typedef logic [ROUTE_W-1:0]   route_t;
    typedef logic [NUM_LINES-1:0] lines_t;
    typedef logic [MSG_W-1:0]     word_t;
endpackage

// File: rtl/irq_chan_state.sv
// Per-channel interrupt state: level status bit and edge pulse.
// Assumes fire_i is a single-cycle strobe and the configuration is steady around it.
module irq_chan_state (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fire_i,
    input  logic en_i,
    input  logic glb_en_i,
    input  logic lvl_i,
    input  logic msg_en_i,
    input  logic clr_i,
    output logic status_o,
    output logic line_o,
    output logic msg_fire_o
);
    logic accepted;
    logic blocked;
    logic msg_en_q;
    logic status_q;
    logic pulse_q;
    logic status_d;

    assign accepted   = fire_i & en_i & glb_en_i;
    assign blocked    = fire_i & ~(en_i & glb_en_i);
    assign msg_fire_o = accepted & msg_en_i;

    // Next status: an accepted level fire sets, blocking/clear/message-enable rise clears.
    always_comb begin
        status_d = status_q;
        if (accepted && lvl_i && !msg_en_i) begin
            status_d = 1'b1;
        end else if (blocked || clr_i || (msg_en_i && !msg_en_q)) begin
            status_d = 1'b0;
        end
    end

    // Register the status bit, the edge pulse and the previous message enable.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            status_q <= 1'b0;
            pulse_q  <= 1'b0;
            msg_en_q <= 1'b0;
        end else begin
            status_q <= status_d;
            pulse_q  <= accepted & ~lvl_i & ~msg_en_i;
            msg_en_q <= msg_en_i;
        end
    end

    assign status_o = status_q;
    assign line_o   = (status_q & ~msg_en_i) | pulse_q;

    AST_LEVEL_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accepted && lvl_i && !msg_en_i) |=> status_o); // R2
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pulse_q && !fire_i) |=> !pulse_q); // R3
    AST_BLOCK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        blocked |=> (!status_o && !pulse_q)); // R5
    AST_MSG_RISE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (msg_en_i && !msg_en_q && !fire_i) |=> !status_o); // R6
endmodule

// File: rtl/irq_line_map.sv
// Maps per-channel line contributions onto the 32 lines, applying the legacy
// override for channels 0 and 1. Purely combinational; contributions are ORed.
module irq_line_map
    import irq_router_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int LEG_LINE_A = 0,
    parameter int LEG_LINE_B = 8
) (
    input  logic                  legacy_i,
    input  route_t [NUM_CH-1:0]   route_i,
    input  logic   [NUM_CH-1:0]   contrib_i,
    output lines_t                lines_o
);
    route_t [NUM_CH-1:0] eff_route;
    lines_t [NUM_CH-1:0] one_hot;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Pick the effective line index: legacy override for the first two channels.
        if (c == 0) begin : g_leg0
            always_comb eff_route[c] = legacy_i ? route_t'(LEG_LINE_A) : route_i[c];
        end else if (c == 1) begin : g_leg1
            always_comb eff_route[c] = legacy_i ? route_t'(LEG_LINE_B) : route_i[c];
        end else begin : g_plain
            always_comb eff_route[c] = route_i[c];
        end
        // Expand the channel's contribution into a one-hot line vector.
        always_comb one_hot[c] = contrib_i[c] ? (lines_t'(1) << eff_route[c]) : '0;
    end

    // OR all channel vectors together.
    always_comb begin
        lines_o = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            lines_o = lines_o | one_hot[c];
        end
    end

    // Check the legacy override at the line vector.
    always_comb begin
        if (legacy_i && contrib_i[0]) begin
            AST_LEG_CH0_LINE: assert (lines_o[LEG_LINE_A]); // R1
        end
        if (legacy_i && NUM_CH > 1 && contrib_i[NUM_CH > 1 ? 1 : 0]) begin
            AST_LEG_CH1_LINE: assert (lines_o[LEG_LINE_B]); // R1
        end
    end
endmodule

// File: rtl/irq_legacy_ext.sv
// External interval-timer and clock interrupt gating for legacy takeover.
// Records the clock input every cycle and restores it when takeover ends.
module irq_legacy_ext (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic legacy_i,
    input  logic pit_irq_i,
    input  logic rtc_irq_i,
    output logic ext_a_o,
    output logic ext_b_o,
    output logic pit_en_o
);
    logic legacy_q;
    logic rtc_lvl_q;
    logic ext_a_q;
    logic ext_b_q;
    logic pit_en_q;

    // Track mode, record clock level and drive the gated external lines.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            legacy_q  <= 1'b0;
            rtc_lvl_q <= 1'b0;
            ext_a_q   <= 1'b0;
            ext_b_q   <= 1'b0;
            pit_en_q  <= 1'b1;
        end else begin
            legacy_q  <= legacy_i;
            rtc_lvl_q <= rtc_irq_i;
            pit_en_q  <= ~legacy_i;
            if (legacy_i) begin
                ext_a_q <= 1'b0;
                ext_b_q <= 1'b0;
            end else if (legacy_q) begin
                ext_a_q <= 1'b0;
                ext_b_q <= rtc_lvl_q;
            end else begin
                ext_a_q <= pit_irq_i;
                ext_b_q <= rtc_irq_i;
            end
        end
    end

    assign ext_a_o  = ext_a_q;
    assign ext_b_o  = ext_b_q;
    assign pit_en_o = pit_en_q;

    AST_LEGACY_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        legacy_i |=> (!ext_a_o && !ext_b_o && !pit_en_o)); // R8
    AST_LEAVE_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!legacy_i && legacy_q) |=> (!ext_a_o && pit_en_o && ext_b_o == $past(rtc_lvl_q))); // R9
    AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!legacy_i && !legacy_q) |=> (ext_a_o == $past(pit_irq_i) && ext_b_o == $past(rtc_irq_i))); // R7
endmodule

// File: rtl/irq_msg_arb.sv
// Holds one pending message write per channel, captured at the fire, and
// presents them one at a time on a valid/ready port, lowest index first.
// A presented request is locked until accepted.
module irq_msg_arb
    import irq_router_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic  [NUM_CH-1:0]   msg_fire_i,
    input  word_t [NUM_CH-1:0]   addr_i,
    input  word_t [NUM_CH-1:0]   data_i,
    output logic                 valid_o,
    input  logic                 ready_i,
    output word_t                addr_o,
    output word_t                data_o
);
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic  [NUM_CH-1:0] pend_q;
    word_t [NUM_CH-1:0] addr_q;
    word_t [NUM_CH-1:0] data_q;
    logic               lock_q;
    logic  [IDX_W-1:0]  lock_idx_q;
    logic  [IDX_W-1:0]  pick;
    logic  [IDX_W-1:0]  sel;
    logic               accept;

    // Lowest-index pending channel.
    always_comb begin
        pick = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (pend_q[c]) pick = IDX_W'(c);
        end
    end

    assign sel     = lock_q ? lock_idx_q : pick;
    assign valid_o = |pend_q;
    assign accept  = valid_o & ready_i;
    assign addr_o  = addr_q[sel];
    assign data_o  = data_q[sel];

    // Per-channel pending flag and captured message words.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
        logic served;
        logic load;
        assign served = accept && (sel == IDX_W'(c));
        assign load   = msg_fire_i[c] && (!pend_q[c] || served);
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                pend_q[c] <= 1'b0;
                addr_q[c] <= '0;
                data_q[c] <= '0;
            end else begin
                if (load) begin
                    pend_q[c] <= 1'b1;
                    addr_q[c] <= addr_i[c];
                    data_q[c] <= data_i[c];
                end else if (served) begin
                    pend_q[c] <= 1'b0;
                end
            end
        end
    end

    // Lock the presented channel while the consumer stalls.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            lock_q     <= 1'b0;
            lock_idx_q <= '0;
        end else begin
            lock_q     <= valid_o & ~ready_i;
            lock_idx_q <= sel;
        end
    end

    AST_MSG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(data_o))); // R4
    AST_MSG_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|msg_fire_i) |=> valid_o); // R4
endmodule

// File: rtl/irq_legacy_router.sv
// Top of the interrupt router: per-channel state, line mapping with legacy
// override, external interrupt gating and message write port.
// Assumes inputs are synchronous to clk_i; reset is synchronous, active low.
module irq_legacy_router
    import irq_router_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int LEG_LINE_A = 0,
    parameter int LEG_LINE_B = 8
) (
    input  logic                                clk_i,
    input  logic                                rst_ni,
    input  logic [NUM_CH-1:0]                   fire_i,
    input  logic [NUM_CH-1:0]                   ch_en_i,
    input  logic [NUM_CH-1:0]                   ch_lvl_i,
    input  logic [NUM_CH-1:0]                   ch_msg_en_i,
    input  logic [NUM_CH-1:0][ROUTE_W-1:0]      ch_route_i,
    input  logic [NUM_CH-1:0][MSG_W-1:0]        ch_msg_addr_i,
    input  logic [NUM_CH-1:0][MSG_W-1:0]        ch_msg_data_i,
    input  logic                                glb_en_i,
    input  logic                                legacy_i,
    input  logic [NUM_CH-1:0]                   stat_clr_i,
    input  logic                                pit_irq_i,
    input  logic                                rtc_irq_i,
    output logic [NUM_LINES-1:0]                irq_o,
    output logic [NUM_CH-1:0]                   status_o,
    output logic                                msg_valid_o,
    input  logic                                msg_ready_i,
    output logic [MSG_W-1:0]                    msg_addr_o,
    output logic [MSG_W-1:0]                    msg_data_o,
    output logic                                pit_en_o
);
    logic [NUM_CH-1:0] contrib;
    logic [NUM_CH-1:0] msg_fire;
    lines_t            ch_lines;
    logic              ext_a;
    logic              ext_b;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        irq_chan_state u_state (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .fire_i     (fire_i[c]),
            .en_i       (ch_en_i[c]),
            .glb_en_i   (glb_en_i),
            .lvl_i      (ch_lvl_i[c]),
            .msg_en_i   (ch_msg_en_i[c]),
            .clr_i      (stat_clr_i[c]),
            .status_o   (status_o[c]),
            .line_o     (contrib[c]),
            .msg_fire_o (msg_fire[c])
        );
    end

    irq_line_map #(
        .NUM_CH     (NUM_CH),
        .LEG_LINE_A (LEG_LINE_A),
        .LEG_LINE_B (LEG_LINE_B)
    ) u_map (
        .legacy_i  (legacy_i),
        .route_i   (ch_route_i),
        .contrib_i (contrib),
        .lines_o   (ch_lines)
    );

    irq_legacy_ext u_ext (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .legacy_i  (legacy_i),
        .pit_irq_i (pit_irq_i),
        .rtc_irq_i (rtc_irq_i),
        .ext_a_o   (ext_a),
        .ext_b_o   (ext_b),
        .pit_en_o  (pit_en_o)
    );

    irq_msg_arb #(
        .NUM_CH (NUM_CH)
    ) u_msg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .msg_fire_i (msg_fire),
        .addr_i     (ch_msg_addr_i),
        .data_i     (ch_msg_data_i),
        .valid_o    (msg_valid_o),
        .ready_i    (msg_ready_i),
        .addr_o     (msg_addr_o),
        .data_o     (msg_data_o)
    );

    // Merge channel lines with the gated external inputs.
    always_comb begin
        irq_o = ch_lines;
        irq_o[LEG_LINE_A] = irq_o[LEG_LINE_A] | ext_a;
        irq_o[LEG_LINE_B] = irq_o[LEG_LINE_B] | ext_b;
    end
endmodule

// File: tb/irq_legacy_router_tb.sv
`timescale 1ns/1ps
module irq_legacy_router_tb_top;
    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] fire = '0, en = '0, lvl = '0, msg_en = '0, clr = '0;
    logic [NCH-1:0][4:0]  route = '0;
    logic [NCH-1:0][31:0] maddr = '0, mdata = '0;
    logic glb = 1'b0, legacy = 1'b0, pit = 1'b0, rtc = 1'b0, ready = 1'b0;
    logic [31:0] irq;
    logic [NCH-1:0] status;
    logic mvalid, pit_en;
    logic [31:0] oaddr, odata;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    irq_legacy_router #(.NUM_CH(NCH)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .fire_i(fire), .ch_en_i(en), .ch_lvl_i(lvl),
        .ch_msg_en_i(msg_en), .ch_route_i(route), .ch_msg_addr_i(maddr),
        .ch_msg_data_i(mdata), .glb_en_i(glb), .legacy_i(legacy), .stat_clr_i(clr),
        .pit_irq_i(pit), .rtc_irq_i(rtc), .irq_o(irq), .status_o(status),
        .msg_valid_o(mvalid), .msg_ready_i(ready), .msg_addr_o(oaddr),
        .msg_data_o(odata), .pit_en_o(pit_en)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        // R10 reset state
        check("R10 irq", 64'(irq), 0);
        check("R10 status", 64'(status), 0);
        check("R10 valid", 64'(mvalid), 0);
        check("R10 pit_en", 64'(pit_en), 1);

        // R1 R3 edge sweep over every channel and route
        glb = 1'b1; en = '1;
        for (int c = 0; c < NCH; c++) begin
            for (int r = 0; r < 32; r++) begin
                route[c] = 5'(r);
                fire[c] = 1'b1;
                step();
                fire[c] = 1'b0;
                check("R1 R3 pulse", 64'(irq), 64'(32'd1 << r));
                check("R3 status untouched", 64'(status), 0);
                step();
                check("R3 pulse ends", 64'(irq), 0);
            end
        end

        // R2 level hold and clear
        route = '0;
        route[2] = 5'd13; lvl[2] = 1'b1;
        fire[2] = 1'b1; step(); fire[2] = 1'b0;
        check("R2 status set", 64'(status), 64'h4);
        check("R2 line high", 64'(irq), 64'(32'd1 << 13));
        step(); step(); step();
        check("R2 line held", 64'(irq), 64'(32'd1 << 13));
        clr[2] = 1'b1; step(); clr[2] = 1'b0;
        check("R2 cleared", 64'(status), 0);
        check("R2 line low", 64'(irq), 0);
        fire[2] = 1'b1; clr[2] = 1'b1; step(); fire[2] = 1'b0; clr[2] = 1'b0;
        check("R2 fire beats clear", 64'(status), 64'h4);

        // R1 OR of two channels on one line (ch3 edge on line 13 while ch2 level high)
        route[3] = 5'd13; fire[3] = 1'b1; step(); fire[3] = 1'b0;
        check("R1 shared line", 64'(irq), 64'(32'd1 << 13));

        // R5 blocked by channel enable
        en[2] = 1'b0; fire[2] = 1'b1; step(); fire[2] = 1'b0;
        check("R5 chan blocked status", 64'(status), 0);
        check("R5 chan blocked line", 64'(irq), 0);
        en[2] = 1'b1;
        fire[2] = 1'b1; step(); fire[2] = 1'b0;
        check("R2 reset for R5", 64'(status), 64'h4);
        glb = 1'b0; fire[2] = 1'b1; step(); fire[2] = 1'b0;
        check("R5 global blocked status", 64'(status), 0);
        check("R5 global blocked line", 64'(irq), 0);
        check("R5 no message", 64'(mvalid), 0);
        glb = 1'b1;

        // R6 message enable rise clears status
        fire[2] = 1'b1; step(); fire[2] = 1'b0;
        check("R6 pre set", 64'(status), 64'h4);
        msg_en[2] = 1'b1; step();
        check("R6 status cleared", 64'(status), 0);
        check("R6 line low", 64'(irq), 0);
        msg_en[2] = 1'b0; lvl[2] = 1'b0; step();

        // R4 message path
        msg_en[1] = 1'b1; msg_en[3] = 1'b1;
        maddr[1] = 32'hA000_0010; mdata[1] = 32'h0000_1111;
        maddr[3] = 32'hA000_0030; mdata[3] = 32'h0000_3333;
        fire[1] = 1'b1; fire[3] = 1'b1; step(); fire = '0;
        check("R4 valid", 64'(mvalid), 1);
        check("R4 no line", 64'(irq), 0);
        check("R4 lowest first addr", 64'(oaddr), 64'hA000_0010);
        check("R4 lowest first data", 64'(odata), 64'h0000_1111);
        maddr[1] = 32'hBEEF_0000; mdata[1] = 32'h0;
        fire[1] = 1'b1; step(); fire = '0; step();
        check("R4 held addr", 64'(oaddr), 64'hA000_0010);
        check("R4 held data", 64'(odata), 64'h0000_1111);
        ready = 1'b1; step();
        check("R4 next addr", 64'(oaddr), 64'hA000_0030);
        check("R4 next data", 64'(odata), 64'h0000_3333);
        step(); ready = 1'b0;
        check("R4 drained", 64'(mvalid), 0);
        msg_en = '0;

        // R7 external passthrough
        pit = 1'b1; step();
        check("R7 pit line", 64'(irq), 64'h1);
        rtc = 1'b1; step();
        check("R7 rtc line", 64'(irq), 64'h101);

        // R8 legacy entry
        legacy = 1'b1; step();
        check("R8 lines low", 64'(irq), 0);
        check("R8 pit_en low", 64'(pit_en), 0);
        route[0] = 5'd20; route[1] = 5'd21; route[2] = 5'd5;
        fire[0] = 1'b1; fire[1] = 1'b1; fire[2] = 1'b1; step(); fire = '0;
        check("R1 legacy override", 64'(irq), 64'h0000_0121);
        rtc = 1'b0; step(); step();
        check("R8 still gated", 64'(irq), 0);
        rtc = 1'b1; step(); step();

        // R9 leaving legacy
        legacy = 1'b0; step();
        check("R9 line0 low", 64'(irq[0]), 0);
        check("R9 line8 restored", 64'(irq[8]), 1);
        check("R9 pit_en high", 64'(pit_en), 1);
        step();
        check("R7 pit resumes", 64'(irq), 64'h101);
        route[0] = 5'd20; fire[0] = 1'b1; step(); fire = '0;
        check("R1 non-legacy route", 64'(irq), 64'h0010_0101);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule